// File: doc/BRIEF.md
# Soft-Mute Ramp Sequencer

This block sits in the digital datapath of an audio DAC. It passes multichannel signed PCM frames from an input stream to an output stream and scales every channel by a shared gain. When the active-low mute pin is pulled low or the clock-error flag rises, the gain falls linearly to zero over a fixed number of frames. A hold timer of 0.2 ms follows, measured on the reference clock. After that the block raises `hard_mute`, which clamps the analog stage to ground. When both triggers clear, `hard_mute` drops first and the gain then climbs back to full over the same number of frames.

During a clock error the input stream can no longer be trusted. The block stops accepting frames and makes output frames itself from an internal fallback timebase. Each such frame repeats the last frame it accepted, scaled by the falling gain. The sequence still ends in hard mute. Both input pins are synchronised inside the block.

Both streams use valid/ready. A frame moves when valid and ready are both high at a clock edge. The output is a single register stage. It can take a new frame only when it is empty or is being emptied in the same cycle, so back-pressure on `m_ready` passes straight through to `s_ready`. While the output is stalled, `m_valid` and `m_data` hold their values.

Top module: `smute_seq`

## Requirements
- R1: After reset `m_valid` is 0, `hard_mute` is 0, `s_ready` is 1 and the gain is at full scale.
- R2: With no trigger active, each channel (lane c in bits `[c*DATA_W +: DATA_W]`) comes out as floor(sample × 65535 / 65536), using a signed sample and arithmetic truncation.
- R3: `s_ready` equals (no synchronised clock error) AND (`m_valid` low OR `m_ready` high). Each accepted frame appears on the output in the next cycle. A stalled output frame holds `m_data` until it is taken.
- R4: Pulling `mute_n` low starts a falling ramp within three cycles. The k-th frame loaded afterwards (k = 1..150) is scaled by gain(150−k), where gain(L) = 65535 for L = 150 and L × 436 otherwise.
- R5: The 150th ramp frame is scaled by zero. `hard_mute` rises exactly REF_HZ/5000 clock cycles after the edge that loaded that frame.
- R6: While a falling ramp is in progress, releasing and then re-asserting a trigger neither restarts the ramp nor raises the gain. The ramp runs on to hard mute.
- R7: In hard mute, once `mute_n` is high and no clock error is flagged, `hard_mute` falls within three cycles. The k-th frame after that is scaled by gain(k), and full gain returns at k = 150.
- R8: A trigger during a rising ramp starts a falling ramp from the current level. The next frames never use a higher gain.
- R9: While a clock error is flagged, `s_ready` is 0. A frame is loaded every FB_DIV cycles from the fallback timebase. Its value is the last accepted frame scaled by the falling-ramp gain.
- R10: A clock-error mute ends in hard mute after the same hold time. It is released when the error clears with `mute_n` high.
- R11: Frames loaded during the hold time or during hard mute are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Input frame valid |
| s_ready | output | 1 | Input frame accepted when high with s_valid |
| s_data | input | CHANNELS*DATA_W | Input frame, one signed sample per lane |
| m_valid | output | 1 | Output frame valid |
| m_ready | input | 1 | Downstream accepts output frame |
| m_data | output | CHANNELS*DATA_W | Scaled output frame |
| mute_n | input | 1 | Asynchronous active-low mute request |
| clk_err | input | 1 | Asynchronous clock-error flag |
| hard_mute | output | 1 | Analog clamp request |

## Verification
An accepted frame is due on the output one cycle after its handshake. The bench computes the expected value at the moment of acceptance, from the gain level its own model holds, and compares it when the output handshake happens. Pin changes take up to three cycles to reach the sequencer. The bench therefore waits six idle cycles after each change and does not compare `hard_mute` during that window. The rise of `hard_mute` is checked on the exact cycle, REF_HZ/5000 cycles after the final ramp frame was loaded. In fallback mode the bench does not predict when frames arrive. It only predicts their order, and it scales the held frame at each output handshake.

// File: rtl/smute_pkg.sv
package smute_pkg;
  typedef enum logic [2:0] {
    ST_OPEN,
    ST_FALL,
    ST_HOLD,
    ST_SHUT,
    ST_RISE
  } mute_st_e;
endpackage

// File: rtl/smute_sync.sv
module smute_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/smute_tick.sv
module smute_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)             cnt <= '0;
    else if (cnt == CW'(DIV - 1))  cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/smute_lane.sv
module smute_lane #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] scaled
);
  logic signed [DATA_W+GAIN_W-1:0] prod;

  assign prod   = $signed(sample) * $signed({1'b0, gain});
  assign scaled = DATA_W'(prod >>> GAIN_W);
endmodule

// File: rtl/smute_ctrl.sv
module smute_ctrl
  import smute_pkg::*;
#(
  parameter int STEPS    = 150,
  parameter int GAIN_W   = 16,
  parameter int HOLD_CYC = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              beat,
  output logic [GAIN_W-1:0] gain_beat,
  output logic              hard
);
  localparam int LW   = $clog2(STEPS + 1);
  localparam int HW   = $clog2(HOLD_CYC + 1);
  localparam int STEP = ((2 ** GAIN_W) - 1) / STEPS;
  localparam logic [GAIN_W-1:0] G_FULL = '1;

  function automatic logic [GAIN_W-1:0] gain_of(input logic [LW-1:0] l);
    if (l == LW'(STEPS)) return G_FULL;
    return GAIN_W'(int'(l) * STEP);
  endfunction

  mute_st_e      st_q, st_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [HW-1:0] hcnt_q, hcnt_d;

  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    hcnt_d = hcnt_q;
    case (st_q)
      ST_OPEN: if (trig) st_d = ST_FALL;
      ST_FALL: begin
        if (lvl_q == '0) begin
          st_d   = ST_HOLD;
          hcnt_d = '0;
        end else if (beat) begin
          lvl_d = lvl_q - 1'b1;
          if (lvl_q == LW'(1)) begin
            st_d   = ST_HOLD;
            hcnt_d = '0;
          end
        end
      end
      ST_HOLD: begin
        if (hcnt_q == HW'(HOLD_CYC - 1)) st_d = ST_SHUT;
        else                             hcnt_d = hcnt_q + 1'b1;
      end
      ST_SHUT: if (!trig) st_d = ST_RISE;
      ST_RISE: begin
        if (trig) st_d = ST_FALL;
        else if (beat) begin
          lvl_d = lvl_q + 1'b1;
          if (lvl_q == LW'(STEPS - 1)) st_d = ST_OPEN;
        end
      end
      default: st_d = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_OPEN;
      lvl_q  <= LW'(STEPS);
      hcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      hcnt_q <= hcnt_d;
    end
  end

  assign gain_beat = gain_of(lvl_d);
  assign hard      = (st_q == ST_SHUT);
endmodule

// File: rtl/smute_seq.sv
module smute_seq #(
  parameter int CHANNELS    = 2,
  parameter int DATA_W      = 16,
  parameter int GAIN_W      = 16,
  parameter int RAMP_STEPS  = 150,
  parameter int REF_HZ      = 200_000_000,
  parameter int FB_DIV      = 4167,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [CHANNELS*DATA_W-1:0]   s_data,
  output logic                         m_valid,
  input  logic                         m_ready,
  output logic [CHANNELS*DATA_W-1:0]   m_data,
  input  logic                         mute_n,
  input  logic                         clk_err,
  output logic                         hard_mute
);
  localparam int BUS_W    = CHANNELS * DATA_W;
  localparam int HOLD_CYC = REF_HZ / 5000;

  logic              mute_n_s, err_s, trig;
  logic              fb_tick, fb_pend, slot_free, load;
  logic [GAIN_W-1:0] gain_beat;
  logic [BUS_W-1:0]  held_q, src, scaled;
  logic              m_valid_q;
  logic [BUS_W-1:0]  m_data_q;

  smute_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mute (
    .clk(clk), .rst_n(rst_n), .d(mute_n), .q(mute_n_s)
  );
  smute_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_err (
    .clk(clk), .rst_n(rst_n), .d(clk_err), .q(err_s)
  );

  assign trig = !mute_n_s || err_s;

  smute_tick #(.DIV(FB_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(err_s), .tick(fb_tick)
  );

  assign slot_free = !m_valid_q || m_ready;
  assign s_ready   = !err_s && slot_free;
  assign load      = err_s ? (fb_pend && slot_free) : (s_valid && s_ready);

  always_ff @(posedge clk) begin
    if (!rst_n || !err_s) fb_pend <= 1'b0;
    else if (fb_tick)     fb_pend <= 1'b1;
    else if (load)        fb_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 held_q <= '0;
    else if (s_valid && s_ready) held_q <= s_data;
  end

  assign src = err_s ? held_q : s_data;

  smute_ctrl #(
    .STEPS(RAMP_STEPS), .GAIN_W(GAIN_W), .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .beat(load),
    .gain_beat(gain_beat), .hard(hard_mute)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
    smute_lane #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_lane (
      .sample(src[c*DATA_W +: DATA_W]),
      .gain  (gain_beat),
      .scaled(scaled[c*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid_q <= 1'b0;
      m_data_q  <= '0;
    end else if (load) begin
      m_valid_q <= 1'b1;
      m_data_q  <= scaled;
    end else if (m_ready) begin
      m_valid_q <= 1'b0;
    end
  end

  assign m_valid = m_valid_q;
  assign m_data  = m_data_q;
endmodule

// File: rtl/smute_sva.sv
module smute_sva #(
  parameter int BUS_W  = 32,
  parameter int GAIN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [BUS_W-1:0]  m_data,
  input logic              hard_mute,
  input logic              trig,
  input logic              err_s,
  input logic [GAIN_W-1:0] gain_beat
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data)); // R3

  AST_CLAMP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hard_mute |-> gain_beat == '0); // R5

  AST_NO_GAIN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    trig && $past(trig) |-> gain_beat <= $past(gain_beat)); // R6

  AST_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hard_mute) |-> !$past(trig)); // R7

  AST_ERR_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    err_s |-> !s_ready); // R9
endmodule

bind smute_seq smute_sva #(.BUS_W(CHANNELS*DATA_W), .GAIN_W(GAIN_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .hard_mute(hard_mute),
  .trig(trig), .err_s(err_s), .gain_beat(gain_beat)
);

// File: tb/smute_seq_tb.sv
module smute_seq_tb;
  localparam int CH   = 2;
  localparam int DW   = 16;
  localparam int REF  = 10_000_000;
  localparam int HOLD = REF / 5000;
  localparam int FB   = 4;
  localparam int N    = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b1;
  logic [CH*DW-1:0] s_data = '0, m_data;
  logic mute_n = 1'b1, clk_err = 1'b0, hard_mute;

  always #2.5 clk = ~clk;

  smute_seq #(
    .CHANNELS(CH), .DATA_W(DW), .GAIN_W(16), .RAMP_STEPS(N),
    .REF_HZ(REF), .FB_DIV(FB), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .mute_n(mute_n), .clk_err(clk_err), .hard_mute(hard_mute)
  );

  int n_chk = 0, n_fail = 0, tickn = 0, acc_cnt = 0;
  int mst = 0, mlvl = N, hold_start = 0;
  bit d_valid = 0, d_ready = 1, d_mute_n = 1, d_err = 0;
  logic [31:0] d_data = '0, last_in = '0, exp_q = '0, stall_q = '0;
  bit exp_ok = 0, fb_mode = 0, hard_chk_en = 1, was_stall = 0;
  string exp_tag = "R2", beat_tag = "R2";

  function automatic int gain_of(int l);
    return (l == N) ? 65535 : l * 436;
  endfunction

  function automatic logic [15:0] scale(logic [15:0] s, int g);
    longint p = longint'($signed(s)) * longint'(g);
    return 16'(p >>> 16);
  endfunction

  function automatic logic [31:0] scale_bus(logic [31:0] d, int g);
    return {scale(d[31:16], g), scale(d[15:0], g)};
  endfunction

  // states: 0 open, 1 falling, 2 hold, 3 hard mute, 4 rising
  function automatic int model_beat(int at);
    if (mst == 1) begin
      if (mlvl > 0) mlvl--;
      beat_tag = fb_mode ? "R9" : ((mlvl == 0) ? "R5" : "R4");
      if (mlvl == 0) begin mst = 2; hold_start = at; end
    end else if (mst == 4) begin
      mlvl++;
      beat_tag = "R7";
      if (mlvl == N) mst = 0;
    end else if (mst == 0) begin
      beat_tag = "R2";
    end else begin
      beat_tag = fb_mode ? "R10" : "R11";
    end
    return gain_of(mlvl);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    int g;
    @(negedge clk);
    tickn++;
    s_valid = d_valid; s_data = d_data; m_ready = d_ready;
    mute_n = d_mute_n; clk_err = d_err;
    #1;
    if (mst == 2 && tickn - hold_start >= HOLD) mst = 3;
    if (hard_chk_en)
      chk(hard_mute == (mst == 3), (mst >= 2 && mst <= 3) ? "R5" : "R7",
          "hard_mute", hard_mute, (mst == 3));
    if (was_stall && m_valid)
      chk(m_data == stall_q, "R3", "stalled data", m_data, stall_q);
    was_stall = m_valid && !m_ready;
    stall_q = m_data;
    if (m_valid && m_ready) begin
      if (fb_mode) begin
        g = model_beat(tickn);
        chk(m_data == scale_bus(last_in, g), beat_tag, "fallback frame",
            m_data, scale_bus(last_in, g));
      end else if (!exp_ok) begin
        chk(0, "R3", "unexpected frame", m_data, 0);
      end else begin
        chk(m_data == exp_q, exp_tag, "frame", m_data, exp_q);
        exp_ok = 0;
      end
    end
    if (s_valid && s_ready) begin
      g = model_beat(tickn + 1);
      exp_q = scale_bus(s_data, g);
      exp_tag = beat_tag;
      exp_ok = 1;
      last_in = s_data;
      acc_cnt++;
    end
  endtask

  task automatic settle(int n);
    hard_chk_en = 0;
    repeat (n) tick();
    hard_chk_en = 1;
  endtask

  task automatic drain();
    d_valid = 0; d_ready = 1;
    repeat (4) tick();
  endtask

  task automatic send(int n, bit rnd_ready);
    int target = acc_cnt + n;
    bit took = 1;
    while (acc_cnt < target) begin
      if (took || !d_valid) d_data = $urandom;
      d_valid = ($urandom % 10) < 7;
      d_ready = rnd_ready ? (($urandom % 10) < 8) : 1'b1;
      took = 0;
      tick();
      took = s_valid && s_ready;
      if (acc_cnt >= target) d_valid = 0;
    end
    drain();
  endtask

  task automatic trigger();
    d_mute_n = 0;
    settle(6);
    if (mst == 0 || mst == 4) mst = 1;
  endtask

  task automatic release_all();
    d_mute_n = 1; d_err = 0;
    settle(6);
    if (mst == 3) mst = 4;
  endtask

  task automatic wait_hard();
    while (mst != 3) tick();
    repeat (5) tick();
    chk(hard_mute == 1'b1, "R5", "hard mute after hold", hard_mute, 1);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(m_valid == 1'b0, "R1", "m_valid", m_valid, 0);
    chk(hard_mute == 1'b0, "R1", "hard_mute", hard_mute, 0);
    chk(s_ready == 1'b1, "R1", "s_ready", s_ready, 1);

    // R2 unity path with back-pressure (R3)
    send(40, 1);
    d_valid = 1; d_data = 32'h8000_7FFF; tick(); d_valid = 0; drain();

    // R4 falling ramp, R6 release/retrigger mid-ramp
    trigger();
    send(75, 1);
    d_mute_n = 1; settle(6);
    d_mute_n = 0; settle(6);
    chk(mst == 1 && mlvl == N - 75, "R6", "ramp level kept", mlvl, N - 75);
    send(75, 0);
    wait_hard();
    send(5, 1);   // R11 frames in hard mute

    // R7 release and rising ramp
    release_all();
    chk(hard_mute == 1'b0, "R7", "hard mute released", hard_mute, 0);
    send(40, 1);
    // R8 trigger during rising ramp
    trigger();
    send(40, 1);
    wait_hard();
    release_all();
    send(N, 1);
    send(20, 1);
    chk(mst == 0, "R7", "back to full gain", mst, 0);

    // R9 clock error: fallback from last frame
    d_valid = 1; d_data = 32'h7FFF_8001; tick(); d_valid = 0; drain();
    d_err = 1; fb_mode = 1;
    if (mst == 0 || mst == 4) mst = 1;
    repeat (4) tick();
    chk(s_ready == 1'b0, "R9", "s_ready during clock error", s_ready, 0);
    wait_hard();   // R10
    repeat (20) tick();
    d_err = 0; d_mute_n = 1;
    settle(6);
    fb_mode = 0;
    if (mst == 3) mst = 4;
    chk(hard_mute == 1'b0, "R10", "release after clock error", hard_mute, 0);
    chk(s_ready == 1'b1, "R10", "s_ready after clock error", s_ready, 1);
    send(N, 1);
    send(10, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule